// File: doc/BRIEF.md
# Load-Switch Operating Mode Controller

This block sequences the operating modes of a two-channel load switch that a host drives over a serial register port. It tracks six modes: sleep, start-up initialization, configuration (all outputs off), active (at least one output on), low-power, and a limp-home fallback. From the mode and a small set of held register fields it decides which channel outputs may drive and when the register file must be wiped. It also selects the gate discharge path, and enables the per-channel output pulldown resistors.

The host wakes the block by pulling chip-select low. It waits for the initialization-done pulse and then writes the configuration. It turns channels on through a control register and moves between the normal and low-power modes with commands to a mode register. Configuration is wiped each time the block falls asleep and is kept through low-power mode, so a channel that was on before low-power turns back on at once when low-power ends. The limp-home mode follows the watchdog-expired flag and the limp-home pin.

Top module: `ldsw_mode_ctrl`

## Requirements
- R1: Mode codes are sleep=0, init=1, config=2, active=3, low-power=4, limp=5. After reset the mode is sleep. A falling edge on `cs_n` in sleep moves to init within a few cycles. An `init_done` pulse in init moves to config.
- R2: `regs_clr` is high for exactly one cycle each time sleep is entered (including the first cycle after reset), and only while the mode is sleep. The register file is cleared by it.
- R3: Register writes are ignored in sleep and in init.
- R4: Writes to the control register (address 3, bit i requests channel i) are ignored until the device register (address 0) has been written since the last clear.
- R5: In config, a nonzero channel request moves the mode to active on the next cycle, and clearing all requests returns it to config. `ch_on` equals the request bits in active and is zero in every other mode.
- R6: The parallel bit (address 0, bit 0, seen on `par_mode`) is writable in config. In active, `par_lock` is high, and writes leave the bit unchanged.
- R7: Writing 1 to mode-register bits [1:0] (address 4) in config or active enters low-power, where outputs are off and all writes except to address 4 are ignored. Writing 0 there returns to active if any request is held, otherwise to config, with all configuration kept.
- R8: Writing 2 to mode-register bits [1:0] in config, active or low-power enters sleep and clears every register.
- R9: Limp is entered from config, active or low-power when `wdog_expired` and `limp_pin` are both high. It is left to config only once both are low.
- R10: `gate_pd_gnd` is high (gate-to-ground) in sleep, init and low-power, and low (gate-to-source) in config, active and limp.
- R11: Channel i's pulldown field is address 1+i, bits [1:0]. `ol_pd_en[i]` is high when that field is nonzero, the mode is config or active, and channel i is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip-select, falling edge wakes from sleep |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| wdog_expired | input | 1 | Serial watchdog has expired |
| limp_pin | input | 1 | Limp-home request pin level |
| init_done | input | 1 | Initialization and self-check finished (pulse) |
| regs_clr | output | 1 | Register-file clear, one cycle on sleep entry |
| par_lock | output | 1 | Parallel bit write-protected |
| gate_pd_gnd | output | 1 | 1 = gate-to-ground pulldown, 0 = gate-to-source |
| ol_pd_en | output | NCH | Per-channel output pulldown resistor enable |
| ch_on | output | NCH | Per-channel output enable to the driver |
| par_mode | output | 1 | Current parallel-mode bit |
| mode | output | 3 | Current operating mode code |

## Verification
On every cycle, the bound checker enforces the relations between the mode and the outputs. Channels drive only in active, the gate path follows the mode, and pulldowns are never enabled on a driven channel. The clear pulse lasts one cycle and occurs only in sleep, the parallel bit holds while active persists, sleep exits only to init, and limp is entered only on the watchdog-plus-pin condition. The data-dependent behaviour can only be shown by the directed scenarios. These cover ignored writes in sleep and init, the request lockout before the device register is written, retention across low-power and the return to active, and the loss of every field after a sleep command.

// File: rtl/ldsw_pkg.sv
package ldsw_pkg;

  typedef enum logic [2:0] {
    MD_SLEEP  = 3'd0,
    MD_INIT   = 3'd1,
    MD_CONFIG = 3'd2,
    MD_ACTIVE = 3'd3,
    MD_LPM    = 3'd4,
    MD_LIMP   = 3'd5
  } mode_e;

  localparam logic [1:0] CMD_RUN   = 2'b00;
  localparam logic [1:0] CMD_LPM   = 2'b01;
  localparam logic [1:0] CMD_SLEEP = 2'b10;

endpackage

// File: rtl/ldsw_wake_det.sv
module ldsw_wake_det (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic wake
);

  logic sync_q1;
  logic sync_q2;
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q1 <= 1'b1;
      sync_q2 <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync_q1 <= cs_n;
      sync_q2 <= sync_q1;
      prev_q  <= sync_q2;
    end
  end

  assign wake = prev_q & ~sync_q2;

endmodule

// File: rtl/ldsw_regs.sv
module ldsw_regs #(
  parameter int NCH      = 2,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int ADR_DEV  = 0,
  parameter int ADR_CH0  = 1,
  parameter int ADR_CTRL = 3,
  parameter int ADR_MODE = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 wr_ok,
  input  logic                 par_lock,
  output logic                 par_mode,
  output logic [NCH-1:0]       out_req,
  output logic [NCH-1:0][1:0]  pd_fld,
  output logic                 cmd_run,
  output logic                 cmd_lpm,
  output logic                 cmd_sleep
);
  import ldsw_pkg::*;

  logic cfg_valid;
  logic dev_we;
  logic ctrl_we;
  logic mode_hit;
  logic unused_data;

  assign unused_data = ^wr_data;

  assign dev_we   = wr_en && wr_ok && (wr_addr == ADDR_W'(ADR_DEV));
  assign ctrl_we  = wr_en && wr_ok && cfg_valid && (wr_addr == ADDR_W'(ADR_CTRL));
  assign mode_hit = wr_en && (wr_addr == ADDR_W'(ADR_MODE));

  assign cmd_run   = mode_hit && (wr_data[1:0] == CMD_RUN);
  assign cmd_lpm   = mode_hit && (wr_data[1:0] == CMD_LPM);
  assign cmd_sleep = mode_hit && (wr_data[1:0] == CMD_SLEEP);

  // device register: parallel bit and configuration-written flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_valid <= 1'b0;
      par_mode  <= 1'b0;
    end else if (clr) begin
      cfg_valid <= 1'b0;
      par_mode  <= 1'b0;
    end else if (dev_we) begin
      cfg_valid <= 1'b1;
      if (!par_lock) begin
        par_mode <= wr_data[0];
      end
    end
  end

  // channel request register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_req <= '0;
    end else if (clr) begin
      out_req <= '0;
    end else if (ctrl_we) begin
      out_req <= wr_data[NCH-1:0];
    end
  end

  // per-channel pulldown fields
  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    logic ch_we;
    assign ch_we = wr_en && wr_ok && (wr_addr == ADDR_W'(ADR_CH0 + gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pd_fld[gi] <= 2'b00;
      end else if (clr) begin
        pd_fld[gi] <= 2'b00;
      end else if (ch_we) begin
        pd_fld[gi] <= wr_data[1:0];
      end
    end
  end

endmodule

// File: rtl/ldsw_fsm.sv
module ldsw_fsm (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake,
  input  logic              init_done,
  input  logic              wdog_expired,
  input  logic              limp_pin,
  input  logic              cmd_run,
  input  logic              cmd_lpm,
  input  logic              cmd_sleep,
  input  logic              req_any,
  output ldsw_pkg::mode_e   state,
  output logic              regs_clr
);
  import ldsw_pkg::*;

  mode_e state_nxt;
  logic  clr_nxt;
  logic  limp_go;
  logic  limp_done;

  assign limp_go   = wdog_expired && limp_pin;
  assign limp_done = !wdog_expired && !limp_pin;

  always_comb begin
    state_nxt = state;
    unique case (state)
      MD_SLEEP: begin
        if (wake) state_nxt = MD_INIT;
      end
      MD_INIT: begin
        if (init_done) state_nxt = MD_CONFIG;
      end
      MD_CONFIG, MD_ACTIVE: begin
        if (limp_go)                            state_nxt = MD_LIMP;
        else if (cmd_sleep)                     state_nxt = MD_SLEEP;
        else if (cmd_lpm)                       state_nxt = MD_LPM;
        else if (state == MD_CONFIG && req_any) state_nxt = MD_ACTIVE;
        else if (state == MD_ACTIVE && !req_any) state_nxt = MD_CONFIG;
      end
      MD_LPM: begin
        if (limp_go)        state_nxt = MD_LIMP;
        else if (cmd_sleep) state_nxt = MD_SLEEP;
        else if (cmd_run)   state_nxt = req_any ? MD_ACTIVE : MD_CONFIG;
      end
      MD_LIMP: begin
        if (limp_done) state_nxt = MD_CONFIG;
      end
      default: state_nxt = MD_SLEEP;
    endcase
  end

  assign clr_nxt = (state_nxt == MD_SLEEP) && (state != MD_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= MD_SLEEP;
      regs_clr <= 1'b1;
    end else begin
      state    <= state_nxt;
      regs_clr <= clr_nxt;
    end
  end

endmodule

// File: rtl/ldsw_mode_ctrl.sv
module ldsw_mode_ctrl #(
  parameter int NCH      = 2,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int ADR_DEV  = 0,
  parameter int ADR_CH0  = 1,
  parameter int ADR_CTRL = 3,
  parameter int ADR_MODE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wdog_expired,
  input  logic              limp_pin,
  input  logic              init_done,
  output logic              regs_clr,
  output logic              par_lock,
  output logic              gate_pd_gnd,
  output logic [NCH-1:0]    ol_pd_en,
  output logic [NCH-1:0]    ch_on,
  output logic              par_mode,
  output logic [2:0]        mode
);
  import ldsw_pkg::*;

  mode_e                state;
  logic                 wake;
  logic                 wr_ok;
  logic                 cmd_run;
  logic                 cmd_lpm;
  logic                 cmd_sleep;
  logic [NCH-1:0]       out_req;
  logic [NCH-1:0][1:0]  pd_fld;
  logic                 normal_md;

  ldsw_wake_det i_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .wake  (wake)
  );

  ldsw_regs #(
    .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADR_DEV(ADR_DEV), .ADR_CH0(ADR_CH0), .ADR_CTRL(ADR_CTRL), .ADR_MODE(ADR_MODE)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (regs_clr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_ok     (wr_ok),
    .par_lock  (par_lock),
    .par_mode  (par_mode),
    .out_req   (out_req),
    .pd_fld    (pd_fld),
    .cmd_run   (cmd_run),
    .cmd_lpm   (cmd_lpm),
    .cmd_sleep (cmd_sleep)
  );

  ldsw_fsm i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .wake         (wake),
    .init_done    (init_done),
    .wdog_expired (wdog_expired),
    .limp_pin     (limp_pin),
    .cmd_run      (cmd_run),
    .cmd_lpm      (cmd_lpm),
    .cmd_sleep    (cmd_sleep),
    .req_any      (|out_req),
    .state        (state),
    .regs_clr     (regs_clr)
  );

  assign normal_md   = (state == MD_CONFIG) || (state == MD_ACTIVE);
  assign wr_ok       = normal_md;
  assign par_lock    = (state == MD_ACTIVE);
  assign gate_pd_gnd = (state == MD_SLEEP) || (state == MD_INIT) || (state == MD_LPM);
  assign ch_on       = (state == MD_ACTIVE) ? out_req : '0;
  assign mode        = state;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_pd
    assign ol_pd_en[gi] = normal_md && (pd_fld[gi] != 2'b00) && !ch_on[gi];
  end

endmodule

// File: rtl/ldsw_mode_chk.sv
module ldsw_mode_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     mode,
  input logic           regs_clr,
  input logic           par_mode,
  input logic           gate_pd_gnd,
  input logic [NCH-1:0] ch_on,
  input logic [NCH-1:0] ol_pd_en,
  input logic           wdog_expired,
  input logic           limp_pin
);
  import ldsw_pkg::*;

  // R5
  drive_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_on != '0) |-> (mode == MD_ACTIVE));

  // R10
  drive_gate_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_on != '0) |-> !gate_pd_gnd);

  // R11
  pd_off_when_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ol_pd_en & ch_on) == '0);

  // R2
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs_clr |=> !regs_clr);

  // R2
  clr_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs_clr |-> (mode == MD_SLEEP));

  // R6
  par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_ACTIVE) |=> (mode != MD_ACTIVE) || $stable(par_mode));

  // R1
  sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_SLEEP) |=> (mode == MD_SLEEP) || (mode == MD_INIT));

  // R9
  limp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_LIMP) |=> (mode != MD_LIMP) || $past(wdog_expired && limp_pin));

endmodule

bind ldsw_mode_ctrl ldsw_mode_chk #(.NCH(NCH)) i_mode_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode         (mode),
  .regs_clr     (regs_clr),
  .par_mode     (par_mode),
  .gate_pd_gnd  (gate_pd_gnd),
  .ch_on        (ch_on),
  .ol_pd_en     (ol_pd_en),
  .wdog_expired (wdog_expired),
  .limp_pin     (limp_pin)
);

// File: tb/test_ldsw_mode_ctrl.sv
module test_ldsw_mode_ctrl;

  localparam int NCH = 2;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  logic              clk;
  logic              rst_n;
  logic              cs_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              wdog_expired;
  logic              limp_pin;
  logic              init_done;
  logic              regs_clr;
  logic              par_lock;
  logic              gate_pd_gnd;
  logic [NCH-1:0]    ol_pd_en;
  logic [NCH-1:0]    ch_on;
  logic              par_mode;
  logic [2:0]        mode;

  int n_chk;
  int n_fail;

  ldsw_mode_ctrl i_ldsw_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wdog_expired(wdog_expired), .limp_pin(limp_pin),
    .init_done(init_done), .regs_clr(regs_clr), .par_lock(par_lock),
    .gate_pd_gnd(gate_pd_gnd), .ol_pd_en(ol_pd_en), .ch_on(ch_on),
    .par_mode(par_mode), .mode(mode)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(addr);
    wr_data = DATA_W'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic do_wake;
    @(negedge clk);
    cs_n = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (mode == 3'd1) break;
    end
    cs_n = 1'b1;
    check("R1 wake to init", int'(mode), 1);
    check("R10 gate ground in init", int'(gate_pd_gnd), 1);
  endtask

  task automatic do_init;
    @(negedge clk);
    init_done = 1'b1;
    @(negedge clk);
    init_done = 1'b0;
    check("R1 init to config", int'(mode), 2);
    check("R10 gate source in config", int'(gate_pd_gnd), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset mode sleep", int'(mode), 0);
    check("R2 clear after reset", int'(regs_clr), 1);
    check("R5 outputs off in sleep", int'(ch_on), 0);
    @(negedge clk);
    check("R2 clear lasts one cycle", int'(regs_clr), 0);
    check("R10 gate ground in sleep", int'(gate_pd_gnd), 1);
  endtask

  task automatic t_wake_writes;
    wr(0, 1);
    check("R3 write ignored in sleep", int'(par_mode), 0);
    do_wake();
    wr(0, 1);
    check("R3 write ignored in init", int'(par_mode), 0);
    do_init();
  endtask

  task automatic t_cfg_active;
    wr(3, 1);
    @(negedge clk);
    check("R4 request before config stays config", int'(mode), 2);
    check("R4 request before config no drive", int'(ch_on), 0);
    wr(0, 1);
    check("R6 parallel writable in config", int'(par_mode), 1);
    check("R6 no lock in config", int'(par_lock), 0);
    wr(1, 1);
    wr(2, 2);
    check("R11 pulldowns in config", int'(ol_pd_en), 3);
    wr(3, 1);
    @(negedge clk);
    check("R5 enters active", int'(mode), 3);
    check("R5 channel 0 drives", int'(ch_on), 1);
    check("R6 lock in active", int'(par_lock), 1);
    check("R11 pulldown off on driven channel", int'(ol_pd_en), 2);
    wr(0, 0);
    check("R6 parallel held in active", int'(par_mode), 1);
    wr(3, 0);
    @(negedge clk);
    check("R5 back to config", int'(mode), 2);
    check("R5 outputs off", int'(ch_on), 0);
    wr(3, 1);
    @(negedge clk);
    check("R5 active again", int'(mode), 3);
  endtask

  task automatic t_lpm;
    wr(4, 1);
    check("R7 enter low-power", int'(mode), 4);
    check("R7 outputs off in low-power", int'(ch_on), 0);
    check("R10 gate ground in low-power", int'(gate_pd_gnd), 1);
    check("R11 no pulldown in low-power", int'(ol_pd_en), 0);
    wr(3, 0);
    wr(0, 0);
    wr(4, 0);
    check("R7 resume to active", int'(mode), 3);
    check("R7 request kept", int'(ch_on), 1);
    check("R7 parallel kept", int'(par_mode), 1);
    check("R11 pulldown field kept", int'(ol_pd_en), 2);
  endtask

  task automatic t_limp;
    @(negedge clk);
    wdog_expired = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 watchdog alone no limp", int'(mode), 3);
    limp_pin = 1'b1;
    @(negedge clk);
    check("R9 enter limp", int'(mode), 5);
    check("R5 outputs off in limp", int'(ch_on), 0);
    check("R10 gate source in limp", int'(gate_pd_gnd), 0);
    limp_pin = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 stays limp while watchdog expired", int'(mode), 5);
    wdog_expired = 1'b0;
    @(negedge clk);
    check("R9 leave limp to config", int'(mode), 2);
    @(negedge clk);
    check("R5 request restores active", int'(mode), 3);
  endtask

  task automatic t_sleep;
    wr(4, 2);
    check("R8 sleep command", int'(mode), 0);
    check("R2 clear on sleep entry", int'(regs_clr), 1);
    @(negedge clk);
    check("R2 clear one cycle", int'(regs_clr), 0);
    do_wake();
    do_init();
    check("R8 parallel cleared", int'(par_mode), 0);
    check("R8 pulldown fields cleared", int'(ol_pd_en), 0);
    @(negedge clk);
    check("R8 request cleared", int'(mode), 2);
    wr(3, 3);
    @(negedge clk);
    check("R4 request locked after sleep", int'(ch_on), 0);
    wr(0, 0);
    wr(3, 2);
    @(negedge clk);
    check("R4 request accepted after config", int'(ch_on), 2);
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    cs_n = 1'b1;
    wr_en = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    wdog_expired = 1'b0;
    limp_pin = 1'b0;
    init_done = 1'b0;
    t_reset();
    t_wake_writes();
    t_cfg_active();
    t_lpm();
    t_limp();
    t_sleep();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule